// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits (16 by default) and returns the full `2*W`-bit product. The multiplier operand is recoded into radix-4 digits, one for each overlapping three-bit window. Each digit picks a multiple of the multiplicand from the set {-2A, -A, 0, +A, +2A}. These multiples are formed only by shifting and bit inversion. The resulting rows are summed by a carry-save tree of 4:2 compressors into one sum vector and one carry vector.

Sign extension is not replicated across the rows. Each row instead carries an inverted sign bit at its top position, and a single precomputed constant row cancels the offset that this introduces. The two's-complement "+1" owed by every negated row is collected into one extra sparse row. The sum and carry vectors are registered. In the next cycle a `2*W+1`-bit ripple-carry adder resolves them into the product register.

The pipeline has no stall. A new operand pair can be presented on every clock, and each result appears two clocks later, in issue order, with a matching valid flag.

Top module: `booth_mul_pipe`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `out_valid` and `product` are 0 after that edge, whatever the operand inputs carry.
- R2: For an accepted pair, `product` equals the signed product of `a_in` and `b_in` as a `2*W`-bit two's-complement value. The internal `2*W+1`-bit adder result is the sign extension of that value.
- R3: `out_valid` is high in the cycle after the second rising edge that follows an edge with `in_valid` high, and it is high at no other time.
- R4: Pairs presented on consecutive cycles each produce one result, in the order they were presented, with no gap and no loss.
- R5: While `out_valid` is low, `product` keeps its last value.
- R6: The most negative operand times itself gives 0x40000000. The most negative value times the most positive value gives 0xC0008000. A value of -1 times -1 gives 1.
- R7: Multiplier patterns are handled correctly when every radix-4 digit is exercised. Window 001/010 selects +A, 011 selects +2A, 100 selects -2A, 101/110 selects -A, and 000/111 selects 0. The window for digit j is bits 2j+1, 2j and 2j-1 of the multiplier, with bit -1 equal to 0.
- R8: Operand values presented while `in_valid` is low produce no `out_valid` and leave `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on `a_in`/`b_in` is to be multiplied |
| a_in | input | W | Multiplicand, signed two's complement |
| b_in | input | W | Multiplier, signed two's complement |
| out_valid | output | 1 | `product` holds a new result this cycle |
| product | output | 2*W | Signed product of the pair accepted two edges earlier |

## Verification
A wrong selection for a single Booth digit, or a wrong row offset, shows up as a product error equal to a shifted multiple of the multiplicand. It appears on the very result that carried the bad operand pair, two cycles after issue. The same holds for a wrong sign constant or a dropped negation correction, which would corrupt nearly every product involving negative multiples. Corner operands and alternating multiplier patterns are therefore compared exactly, cycle by cycle. A pipeline valid or enable fault shows as a result arriving one cycle early or late, or as a change of `product` while `out_valid` is low. Both are visible at the next clock.

// File: rtl/booth_pkg.sv
// Shared types and elaboration-time helpers for the radix-4 Booth multiplier.
// Assumes: row counts passed to the helpers are at least 1.
package booth_pkg;

    // One recoded radix-4 digit: magnitude select and sign.
    typedef struct packed {
        logic neg;  // digit is negative: invert the selected multiple
        logic one;  // magnitude 1: select the multiplicand
        logic two;  // magnitude 2: select the multiplicand shifted left once
    } booth_digit_t;

    // Rows left after one tree level: each group of four becomes two rows,
    // a remainder of three is squeezed to two, and a remainder of one or two passes.
    function automatic int next_rows(input int r);
        return 2 * (r / 4) + (((r % 4) == 3) ? 2 : (r % 4));
    endfunction

    // Number of compressor levels needed to reach two rows.
    function automatic int tree_levels(input int r);
        int n = 0;
        int x = r;
        while (x > 2) begin
            x = next_rows(x);
            n++;
        end
        return n;
    endfunction

    // Row count present at the input of a given level.
    function automatic int rows_at(input int r, input int lvl);
        int x = r;
        for (int i = 0; i < lvl; i++) begin
            x = next_rows(x);
        end
        return x;
    endfunction

endpackage

// File: rtl/booth_recode.sv
// Radix-4 Booth recoder for one overlapping three-bit window of the multiplier.
// Assumes: grp[0] is the lower neighbour bit (0 for the first window).
module booth_recode
    import booth_pkg::*;
(
    input  logic [2:0]   grp,
    output booth_digit_t dig
);

    // Decode the window into sign and magnitude selects.
    always_comb begin
        dig.one = grp[1] ^ grp[0];
        dig.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
        dig.neg = grp[2] & ~(grp[1] & grp[0]);
    end

endmodule

// File: rtl/booth_pp_row.sv
// Forms one partial-product row from the multiplicand and a recoded digit.
// The row carries an inverted sign bit at its top and is placed at offset 2*IDX.
// The +1 owed by a negated row is NOT added here; the top level collects it.
// Assumes: TW is wide enough to hold the unshifted row (TW >= W+2).
module booth_pp_row
    import booth_pkg::*;
#(
    parameter int W   = 16,
    parameter int TW  = 2 * W + 1,
    parameter int IDX = 0
) (
    input  logic [W-1:0]  a,
    input  booth_digit_t  dig,
    output logic [TW-1:0] row
);

    localparam int PW = W + 2;

    logic [PW-1:0]    mag;
    logic [PW-1:0]    sel;
    logic [PW-1:0]    flagged;
    logic [TW+PW-1:0] placed;

    // Pick 0, A or 2A, sign-extended to the row width.
    always_comb begin
        if (dig.one) begin
            mag = {{2{a[W-1]}}, a};
        end else if (dig.two) begin
            mag = {a[W-1], a, 1'b0};
        end else begin
            mag = '0;
        end
    end

    // Invert for negative digits, replace the sign bit by its complement, then place.
    always_comb begin
        sel     = dig.neg ? ~mag : mag;
        flagged = {~sel[PW-1], sel[PW-2:0]};
        placed  = {{TW{1'b0}}, flagged} << (2 * IDX);
        row     = placed[TW-1:0];
    end

endmodule

// File: rtl/booth_csa32.sv
// Vector 3:2 carry-save adder: three rows in, sum row and shifted carry row out.
// Assumes: the carry leaving the top bit is discarded (modular arithmetic).
module booth_csa32 #(
    parameter int TW = 33
) (
    input  logic [TW-1:0] x,
    input  logic [TW-1:0] y,
    input  logic [TW-1:0] z,
    output logic [TW-1:0] sum,
    output logic [TW-1:0] carry
);

    logic [TW-1:0] maj;

    // Bitwise full add, with the majority bits moved up one position.
    always_comb begin
        sum   = x ^ y ^ z;
        maj   = (x & y) | (x & z) | (y & z);
        carry = {maj[TW-2:0], 1'b0};
    end

endmodule

// File: rtl/booth_csa42.sv
// Vector 4:2 compressor built from two chained 3:2 stages.
// Assumes: modular arithmetic over TW bits.
module booth_csa42 #(
    parameter int TW = 33
) (
    input  logic [TW-1:0] r0,
    input  logic [TW-1:0] r1,
    input  logic [TW-1:0] r2,
    input  logic [TW-1:0] r3,
    output logic [TW-1:0] sum,
    output logic [TW-1:0] carry
);

    logic [TW-1:0] s_mid;
    logic [TW-1:0] c_mid;

    booth_csa32 #(.TW(TW)) u_first (
        .x(r0), .y(r1), .z(r2), .sum(s_mid), .carry(c_mid)
    );

    booth_csa32 #(.TW(TW)) u_second (
        .x(s_mid), .y(c_mid), .z(r3), .sum(sum), .carry(carry)
    );

endmodule

// File: rtl/booth_ctree.sv
// Carry-save reduction tree: ROWS rows down to one sum and one carry row.
// Each level groups rows by four into 4:2 compressors; a leftover group of three
// goes through a 3:2 stage and leftovers of one or two pass straight through.
// Assumes: ROWS >= 2.
module booth_ctree
    import booth_pkg::*;
#(
    parameter int TW   = 33,
    parameter int ROWS = 11
) (
    input  logic [TW-1:0] rows_in [ROWS],
    output logic [TW-1:0] sum,
    output logic [TW-1:0] carry
);

    localparam int LEVELS = tree_levels(ROWS);

    logic [TW-1:0] lv [LEVELS+1][ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_in
        assign lv[0][r] = rows_in[r];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int RIN  = rows_at(ROWS, l);
        localparam int ROUT = rows_at(ROWS, l + 1);
        localparam int NQ   = RIN / 4;
        localparam int REM  = RIN % 4;

        for (genvar q = 0; q < NQ; q++) begin : g_quad
            booth_csa42 #(.TW(TW)) u_c42 (
                .r0   (lv[l][4*q]),
                .r1   (lv[l][4*q+1]),
                .r2   (lv[l][4*q+2]),
                .r3   (lv[l][4*q+3]),
                .sum  (lv[l+1][2*q]),
                .carry(lv[l+1][2*q+1])
            );
        end

        if (REM == 3) begin : g_rem3
            booth_csa32 #(.TW(TW)) u_c32 (
                .x    (lv[l][4*NQ]),
                .y    (lv[l][4*NQ+1]),
                .z    (lv[l][4*NQ+2]),
                .sum  (lv[l+1][2*NQ]),
                .carry(lv[l+1][2*NQ+1])
            );
        end else begin : g_pass
            for (genvar p = 0; p < REM; p++) begin : g_p
                assign lv[l+1][2*NQ+p] = lv[l][4*NQ+p];
            end
        end

        for (genvar z = ROUT; z < ROWS; z++) begin : g_zero
            assign lv[l+1][z] = '0;
        end
    end

    assign sum   = lv[LEVELS][0];
    assign carry = lv[LEVELS][1];

endmodule

// File: rtl/booth_ripple_add.sv
// Carry-chain adder of N bits built from a row of full-add cells.
// Assumes: carry-in is 0 and the carry out of the top bit is dropped.
module booth_ripple_add #(
    parameter int N = 33
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] s
);

    logic [N-1:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_cell
        assign s[i] = x[i] ^ y[i] ^ c[i];
        if (i < N - 1) begin : g_cy
            assign c[i+1] = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
        end
    end

endmodule

// File: rtl/booth_mul_pipe.sv
// Two-stage pipelined signed multiplier using radix-4 Booth recoding.
// Stage 1: recode, form W/2+1 rows plus a negation-correction row and a sign
// constant row, compress to sum/carry, and register them.
// Stage 2: resolve sum/carry with a ripple adder and register the product.
// Assumes: W is even and at least 4; operands are two's complement; no stall.
module booth_mul_pipe
    import booth_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic           out_valid,
    output logic [2*W-1:0] product
);

    localparam int NPP  = W / 2 + 1;
    localparam int PW   = W + 2;
    localparam int TW   = 2 * W + 1;
    localparam int ROWS = NPP + 2;
    localparam int BEW  = W + 3;

    // Constant that cancels the complemented-sign offset of every row.
    function automatic logic [TW-1:0] sign_const();
        logic [TW-1:0] k = '0;
        for (int i = 0; i < NPP; i++) begin
            if (PW - 1 + 2 * i < TW) begin
                k = k - (TW'(1) << (PW - 1 + 2 * i));
            end
        end
        return k;
    endfunction

    localparam logic [TW-1:0] SIGN_K = sign_const();

    logic [BEW-1:0]  b_ext;
    booth_digit_t    dig [NPP];
    logic [TW-1:0]   rows [ROWS];
    logic [TW-1:0]   neg_row;
    logic [TW-1:0]   t_sum;
    logic [TW-1:0]   t_carry;
    logic            s1_valid;
    logic [TW-1:0]   s1_sum;
    logic [TW-1:0]   s1_carry;
    logic [TW-1:0]   fsum;

    assign b_ext = {b_in[W-1], b_in[W-1], b_in, 1'b0};

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        booth_recode u_rec (
            .grp(b_ext[2*i+2 : 2*i]),
            .dig(dig[i])
        );
        booth_pp_row #(.W(W), .TW(TW), .IDX(i)) u_row (
            .a  (a_in),
            .dig(dig[i]),
            .row(rows[i])
        );
    end

    // Gather the +1 corrections of negated rows at each row's lowest position.
    always_comb begin
        neg_row = '0;
        for (int i = 0; i < NPP; i++) begin
            neg_row[2*i] = dig[i].neg;
        end
    end

    assign rows[NPP]     = neg_row;
    assign rows[NPP + 1] = SIGN_K;

    booth_ctree #(.TW(TW), .ROWS(ROWS)) u_tree (
        .rows_in(rows),
        .sum    (t_sum),
        .carry  (t_carry)
    );

    // Stage 1 register: capture the carry-save pair only for valid inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sum   <= '0;
            s1_carry <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_sum   <= t_sum;
                s1_carry <= t_carry;
            end
        end
    end

    booth_ripple_add #(.N(TW)) u_add (
        .x(s1_sum),
        .y(s1_carry),
        .s(fsum)
    );

    // Stage 2 register: load the resolved product when stage 1 holds a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                product <= fsum[2*W-1:0];
            end
        end
    end

endmodule

// File: rtl/booth_mul_pipe_chk.sv
// Property checker for booth_mul_pipe, attached by bind below.
// Assumes: same W as the bound instance; wide_sum is the stage-2 adder output.
module booth_mul_pipe_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [W-1:0]   a_in,
    input logic [W-1:0]   b_in,
    input logic           out_valid,
    input logic [2*W-1:0] product,
    input logic [2*W:0]   wide_sum,
    input logic           s1_valid
);

    logic signed [2*W-1:0] ref_prod;

    // Reference product from the raw ports, computed at full width.
    always_comb begin
        ref_prod = $signed({{W{a_in[W-1]}}, a_in}) * $signed({{W{b_in[W-1]}}, b_in});
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0)); // R1

    AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (product == $past(ref_prod, 2))); // R2

    AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (wide_sum[2*W] == wide_sum[2*W-1])); // R2

    AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R3

    AST_LATENCY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(product)); // R5

endmodule

bind booth_mul_pipe booth_mul_pipe_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a_in     (a_in),
    .b_in     (b_in),
    .out_valid(out_valid),
    .product  (product),
    .wide_sum (fsum),
    .s1_valid (s1_valid)
);

// File: tb/sim_booth_mul_pipe.sv
// Scoreboard bench: issue() queues expected products, the monitor compares them.
module sim_booth_mul_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int PWD        = 2 * W;

    logic           clk      = 1'b0;
    logic           rst_n    = 1'b0;
    logic           in_valid = 1'b0;
    logic [W-1:0]   a_in     = '0;
    logic [W-1:0]   b_in     = '0;
    logic           out_valid;
    logic [PWD-1:0] product;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [PWD-1:0] q_exp [$];
    int             q_cyc [$];
    string          q_tag [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    booth_mul_pipe #(.W(W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .a_in     (a_in),
        .b_in     (b_in),
        .out_valid(out_valid),
        .product  (product)
    );

    // Edge counter used to time results.
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [PWD-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return p[PWD-1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: present one pair and queue its expected result.
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        a_in     = a;
        b_in     = b;
        q_exp.push_back(model(a, b));
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: compare each result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R3", "out_valid without issued pair", 1, 0);
            end else begin
                logic [PWD-1:0] e;
                int             ec;
                string          t;
                e  = q_exp.pop_front();
                ec = q_cyc.pop_front();
                t  = q_tag.pop_front();
                check(product == e, t, "product", product, e);
                check(cyc == ec, "R3", "result cycle", cyc, ec);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            check(1'b0, "R4", "watchdog expired", cyc, 0);
            finish_run();
        end
    end

    initial begin
        logic [PWD-1:0] held;

        // R1: reset wins over a valid input.
        in_valid = 1'b1;
        a_in     = 16'h1234;
        b_in     = 16'h4321;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(product == '0, "R1", "product in reset", product, 0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        idle(2);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R6: extreme operands.
        issue(16'h8000, 16'h8000, "R6");
        issue(16'h8000, 16'h7FFF, "R6");
        issue(16'hFFFF, 16'hFFFF, "R6");
        issue(16'h7FFF, 16'h7FFF, "R6");
        issue(16'h0000, 16'h8000, "R6");
        idle(3);
        check(model(16'h8000, 16'h8000) == 32'h40000000, "R6", "model min*min", 0, 0);

        // R7: multiplier patterns covering every Booth digit value.
        issue(16'h1357, 16'h5555, "R7");
        issue(16'hB00F, 16'hAAAA, "R7");
        issue(16'h7FFF, 16'h3333, "R7");
        issue(16'h8001, 16'hCCCC, "R7");
        issue(16'hFFFE, 16'h6666, "R7");
        issue(16'h0001, 16'h9999, "R7");
        issue(16'h8000, 16'hFFFF, "R7");
        issue(16'h2222, 16'h0001, "R7");
        idle(3);

        // R2/R4: back-to-back random stream.
        for (int i = 0; i < 300; i++) begin
            issue(W'($urandom), W'($urandom), "R4");
        end
        idle(3);

        // R5: results separated by gaps; product must hold between them.
        for (int i = 0; i < 20; i++) begin
            issue(W'($urandom), W'($urandom), "R2");
            idle(1 + (i % 3));
        end
        idle(3);

        // R8: operands changing with in_valid low are ignored.
        held = product;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_in     = W'($urandom);
            b_in     = W'($urandom);
            check(out_valid == 1'b0, "R8", "out_valid while idle", out_valid, 0);
            check(product == held, "R8", "product while idle", product, held);
        end
        idle(2);
        check(product == held, "R5", "product held", product, held);

        check(q_exp.size() == 0, "R4", "undelivered results", q_exp.size(), 0);
        finish_run();
    end

endmodule